// File: doc/BRIEF.md
# Synchronous Transfer Period Generator

This block produces the timing strobe that paces synchronous data transfers. Software writes a 5-bit period value that counts input clocks per transfer. The block keeps that value in a small register that holds 5 after reset. It turns the value into a legal period and then produces a strobe that repeats once per period. The strobe is high for the first half of each period, rounded down, and low for the rest.

Programmed values below the legal minimum of 5 clocks behave as 5. This includes the value 4, which also gives a 5-clock period. The upper limit is 35 clocks. A 5-bit field cannot reach that limit, so every value from 5 to 31 gives exactly that many clocks. A new period value is applied only at a period boundary, so a period that is already running is never cut short or stretched. When the run enable is low, the strobe is low and the phase counter rests at zero. When the enable goes high again, a fresh period starts with its high half.

Top module: `sync_period_gen`

## Requirements
- R1: After reset, `xfer_strobe` is 0 and the stored period value is 5. Enabling without any write therefore gives a 5-clock period.
- R2: A stored value V with 5 <= V <= 31 gives a strobe period of exactly V clocks. The period repeats for as long as `run_en` stays high.
- R3: A stored value from 0 to 4 gives a 5-clock period.
- R4: Within each period of P clocks, `xfer_strobe` is high for the first floor(P/2) clocks and low for the remaining P - floor(P/2) clocks.
- R5: A write while a period is running leaves that period unchanged. The next period uses the new value. This holds even when the write lands on the last clock edge before the boundary.
- R6: While `run_en` is low, `xfer_strobe` is 0 in that same cycle and the phase counter holds at zero. On the first cycle after `run_en` rises and is sampled, a full period starts with its high half.
- R7: `per_val` is stored only on a clock edge where `per_we` is 1. Changing `per_val` while `per_we` is 0 has no effect on the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; the period counts edges of this clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_en | input | 1 | Runs the period generator when 1 |
| per_we | input | 1 | Write strobe for the period value |
| per_val | input | 5 | Period value in input clocks |
| xfer_strobe | output | 1 | Transfer timing strobe, one high phase per period |

## Verification
The hardest case to reach from the ports is a write to the period value that lands inside a running period. The worst version is a write on the very edge before the boundary, where it races the reload. The stimulus writes the new value while the sampling loop is running, at chosen sample indices: early in the period, and one clock before the wrap. It then compares the whole sampled waveform against the old period followed by the new one. Disabling the generator part-way through a period and re-enabling it covers the counter restart.

// File: rtl/sp_pkg.sv
package sp_pkg;

  typedef enum logic {
    SP_IDLE = 1'b0,
    SP_RUN  = 1'b1
  } sp_state_e;

  // Bound a requested clock count into [lo, hi].
  function automatic int unsigned sp_bound(input int unsigned v,
                                           input int unsigned lo,
                                           input int unsigned hi);
    if (v < lo)      return lo;
    else if (v > hi) return hi;
    else             return v;
  endfunction

endpackage

// File: rtl/sp_cfg_reg.sv
module sp_cfg_reg #(
  parameter int RAW_W   = 5,
  parameter int RST_RAW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [RAW_W-1:0] wr_data,
  output logic [RAW_W-1:0] raw_q
);

  logic [RAW_W-1:0] raw_d;

  always_comb begin
    raw_d = raw_q;
    if (wr_en) raw_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= RAW_W'(RST_RAW);
    else        raw_q <= raw_d;
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(raw_q)); // R7

endmodule

// File: rtl/sp_period_clamp.sv
module sp_period_clamp #(
  parameter int RAW_W    = 5,
  parameter int MIN_CLKS = 5,
  parameter int MAX_CLKS = 35,
  parameter int CNT_W    = 6
) (
  input  logic [RAW_W-1:0] raw,
  output logic [CNT_W-1:0] clks
);

  import sp_pkg::*;

  always_comb begin
    clks = CNT_W'(sp_bound(int'(raw), MIN_CLKS, MAX_CLKS));
  end

endmodule

// File: rtl/sp_phase_ctr.sv
module sp_phase_ctr #(
  parameter int MIN_CLKS = 5,
  parameter int MAX_CLKS = 35,
  parameter int CNT_W    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] per_in,
  output logic             strobe
);

  import sp_pkg::*;

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  sp_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] per_q;
  logic             per_ld;
  logic             last;

  assign last = (cnt_q == per_q - ONE);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    per_ld  = 1'b0;
    if (!en) begin
      state_d = SP_IDLE;
      cnt_d   = '0;
      per_ld  = 1'b1;
    end else if (state_q == SP_IDLE) begin
      state_d = SP_RUN;
      cnt_d   = '0;
      per_ld  = 1'b1;
    end else if (last) begin
      cnt_d  = '0;
      per_ld = 1'b1;
    end else begin
      cnt_d = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SP_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      per_q <= CNT_W'(MIN_CLKS);
    else if (per_ld) per_q <= per_in;
  end

  assign strobe = en && (state_q == SP_RUN) && (cnt_q < (per_q >> 1));

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SP_RUN) |-> (cnt_q < per_q)); // R2
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state_q == SP_RUN && last) |=> (cnt_q == '0)); // R2
  AST_PERIOD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (per_q >= CNT_W'(MIN_CLKS)) && (per_q <= CNT_W'(MAX_CLKS))); // R3
  AST_MID_PERIOD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state_q == SP_RUN && !last) |=> $stable(per_q)); // R5
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0 && state_q == SP_IDLE)); // R6

endmodule

// File: rtl/sync_period_gen.sv
module sync_period_gen #(
  parameter int RAW_W    = 5,
  parameter int MIN_CLKS = 5,
  parameter int MAX_CLKS = 35,
  parameter int RST_RAW  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             per_we,
  input  logic [RAW_W-1:0] per_val,
  output logic             xfer_strobe
);

  localparam int CNT_W = $clog2(MAX_CLKS + 1);

  logic [1:0]       rst_sync;
  logic             rst_int_n;
  logic [RAW_W-1:0] raw_q;
  logic [CNT_W-1:0] per_clks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  sp_cfg_reg #(.RAW_W(RAW_W), .RST_RAW(RST_RAW)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (per_we),
    .wr_data (per_val),
    .raw_q   (raw_q)
  );

  sp_period_clamp #(.RAW_W(RAW_W), .MIN_CLKS(MIN_CLKS), .MAX_CLKS(MAX_CLKS),
                    .CNT_W(CNT_W)) u_clamp (
    .raw  (raw_q),
    .clks (per_clks)
  );

  sp_phase_ctr #(.MIN_CLKS(MIN_CLKS), .MAX_CLKS(MAX_CLKS), .CNT_W(CNT_W)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .en     (run_en),
    .per_in (per_clks),
    .strobe (xfer_strobe)
  );

  AST_RESET_LOW: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_int_n) |-> !xfer_strobe); // R1

endmodule

// File: tb/sync_period_gen_bench.sv
module sync_period_gen_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_en = 1'b0;
  logic       per_we = 1'b0;
  logic [4:0] per_val = 5'd0;
  logic       xfer_strobe;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  sync_period_gen u_sync_period_gen (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .per_we(per_we),
    .per_val(per_val), .xfer_strobe(xfer_strobe)
  );

  // {stored value, expected period in clocks}
  localparam logic [11:0] VEC [0:9] = '{
    {6'd0, 6'd5},  {6'd3, 6'd5},   {6'd4, 6'd5},   {6'd5, 6'd5},
    {6'd6, 6'd6},  {6'd7, 6'd7},   {6'd12, 6'd12}, {6'd17, 6'd17},
    {6'd30, 6'd30}, {6'd31, 6'd31}
  };

  function automatic logic exp_bit(input int idx, input int p1, input int p2);
    int j;
    if (idx < p1) return logic'(idx < p1 / 2);
    j = (idx - p1) % p2;
    return logic'(j < p2 / 2);
  endfunction

  // Optionally store a value, enable, then sample p1+p2+1 cycles.
  // At sample act_idx, drive per_val=act_val with per_we=act_we.
  task automatic run_check(input bit do_wr, input int raw, input int p1,
                           input int p2, input int act_idx, input int act_val,
                           input bit act_we, input string req);
    int bad = 0;
    int bad_idx = -1;
    logic act_v = 1'b0;
    logic exp_v = 1'b0;
    @(negedge clk);
    run_en = 1'b0;
    if (do_wr) begin
      per_we  = 1'b1;
      per_val = 5'(raw);
    end
    @(negedge clk);
    per_we = 1'b0;
    run_en = 1'b1;
    for (int i = 0; i <= p1 + p2; i++) begin
      @(negedge clk);
      per_we = 1'b0;
      if (xfer_strobe !== exp_bit(i, p1, p2)) begin
        if (bad == 0) begin
          bad_idx = i;
          act_v   = xfer_strobe;
          exp_v   = exp_bit(i, p1, p2);
        end
        bad++;
      end
      if (i == act_idx) begin
        per_we  = act_we;
        per_val = 5'(act_val);
      end
    end
    tests++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s: value %0d, sample %0d strobe actual %b expected %b",
               req, raw, bad_idx, act_v, exp_v);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    int lows;
    // R1: reset state
    per_val = 5'd17;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    tests++;
    if (xfer_strobe !== 1'b0) begin
      fails++;
      $display("FAIL R1: strobe after reset actual %b expected 0", xfer_strobe);
    end
    // R1: default period 5 with no write (per_val=17 but per_we never high)
    run_check(1'b0, 5, 5, 5, -1, 0, 1'b0, "R1");

    // R2/R3/R4: table walk
    for (int k = 0; k < 10; k++) begin
      run_check(1'b1, int'(VEC[k][11:6]), int'(VEC[k][5:0]),
                int'(VEC[k][5:0]), -1, 0, 1'b0,
                (VEC[k][11:6] < 6'd5) ? "R3/R4" : "R2/R4");
    end

    // R5: write early in a running period
    run_check(1'b1, 10, 10, 6, 2, 6, 1'b1, "R5");
    // R5: write on the edge just before the boundary
    run_check(1'b1, 12, 12, 7, 10, 7, 1'b1, "R5");

    // R7: data change without write enable is ignored
    run_check(1'b1, 7, 7, 7, 1, 20, 1'b0, "R7");

    // R6: disable in the middle of a period
    @(negedge clk);
    @(negedge clk);
    run_en = 1'b0;
    #1;
    lows = (xfer_strobe === 1'b0) ? 1 : 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (xfer_strobe === 1'b0) lows++;
    end
    tests++;
    if (lows != 5) begin
      fails++;
      $display("FAIL R6: low samples while disabled actual %0d expected 5", lows);
    end
    // R6: re-enable restarts a full period (stored value still 7)
    run_check(1'b0, 7, 7, 7, -1, 0, 1'b0, "R6");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule